// File: doc/BRIEF.md
# Peripheral Interface Register File

This block is the byte-wide register front end of a general-purpose peripheral interface. It holds two 8-bit bidirectional ports with per-bit direction control, three plain control bytes, a seven-source interrupt flag set with a matching enable set, and one active-high interrupt line per unit. A parameter chooses one or two units. When there are two, one address bit picks the unit and four lower address bits pick one of sixteen registers inside it.

The host bus is a simple synchronous strobe. Read data is combinational from the selected register. Read side effects and all writes take effect at the clock edge that ends the access. Interrupt sources outside the block raise single-cycle strobes, one per flag. The enable set is written through a set/clear convention. Flags are cleared by writing ones. The two timer flags are also cleared by particular byte accesses to the timer registers. The timer counters, the shifter, the handshake modes and input latching live elsewhere, and the timer bytes read back as zero here.

Top module: `pif_regfile`

## Requirements
- R1: The register index is taken from address bits 12..9. With two units, address bit 13 selects the unit (0 or 1). An access changes only the selected unit, and other address bits have no effect.
- R2: After reset every stored register, flag and enable is zero, `irq` is low and the output enables are zero. A port read then returns the input pins.
- R3: Writing index 14 with data bit 7 set ORs data bits 6..0 into the enables. With bit 7 clear, the same write clears those enables. Reading index 14 returns the enables in bits 6..0 and a 1 in bit 7.
- R4: Writing index 13 clears each flag whose data bit (6..0) is 1 and leaves the others unchanged. If an event strobe arrives in the same cycle as the clear, the strobe wins and its flag ends up set.
- R5: A strobe on event input k (k = 0..6) sets flag bit k whether or not bit k is enabled. Bit 5 is the second timer and bit 6 is the first timer.
- R6: Reading index 13 returns the flags in bits 6..0. Bit 7 is 1 when any flag is set and enabled. The unit's `irq` output equals that bit, and it changes at the same clock edge as the flag or enable that causes it.
- R7: Reading index 8 or writing index 9 clears flag 5. Reading index 4 or writing index 5 clears flag 6. No other access to indices 4..9 changes any flag.
- R8: Indices 0 and 2 are output and direction for port B. Indices 1 and 3 are the same for port A. A port read returns the output bit where the direction bit is 1 and the input pin where it is 0. The output-enable vector equals the direction register, and the output vector equals the output register.
- R9: Index 15 is an alias of index 1 for both reads and writes.
- R10: Indices 4..9 always read as zero. Indices 10, 11 and 12 are plain storage that read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; index and unit fields |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register |
| ev_strobe | input | UNITS*(DATA_W-1) | Per-unit event strobes, one per flag |
| irq | output | UNITS | Per-unit interrupt request |
| pa_in | input | UNITS*DATA_W | Port A input pins |
| pa_out | output | UNITS*DATA_W | Port A output values |
| pa_oe | output | UNITS*DATA_W | Port A output enables |
| pb_in | input | UNITS*DATA_W | Port B input pins |
| pb_out | output | UNITS*DATA_W | Port B output values |
| pb_oe | output | UNITS*DATA_W | Port B output enables |

## Verification
The enable register is swept with computed byte values that alternate between set and clear writes, which separates OR-in from clear-out behaviour. The port mux is swept with unrelated direction, output and pin patterns on both ports of both units, so a swapped mux leg or a crossed port pair changes the result. Each event bit is tried once with only itself enabled and once with every bit but itself enabled; this tells the flag path apart from the summary path. Timer side effects are checked by a sequence of the neutral accesses followed by each clearing access in turn, and a collision cycle shows that a strobe beats a flag clear.

// File: rtl/pif_pkg.sv
package pif_pkg;

   typedef enum logic [3:0] {
      RI_OUT_B     = 4'd0,
      RI_OUT_A     = 4'd1,
      RI_DIR_B     = 4'd2,
      RI_DIR_A     = 4'd3,
      RI_T1_CNT_LO = 4'd4,
      RI_T1_CNT_HI = 4'd5,
      RI_T1_LAT_LO = 4'd6,
      RI_T1_LAT_HI = 4'd7,
      RI_T2_CNT_LO = 4'd8,
      RI_T2_CNT_HI = 4'd9,
      RI_SHIFT     = 4'd10,
      RI_AUX_CTL   = 4'd11,
      RI_PER_CTL   = 4'd12,
      RI_FLAGS     = 4'd13,
      RI_ENABLES   = 4'd14,
      RI_OUT_A_NH  = 4'd15
   } reg_idx_e;

   localparam int IDX_W      = 4;
   localparam int FB_TMR2    = 5;
   localparam int FB_TMR1    = 6;
   localparam int N_PORTS    = 2;
   localparam int N_CTL_REGS = 3;

endpackage

// File: rtl/pif_port.sv
module pif_port #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_out,
   input  logic         wr_dir,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pin_in,
   output logic [W-1:0] out_q,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] rd_val
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         dir_q <= '0;
      end else begin
         if (wr_out) out_q <= wdata;
         if (wr_dir) dir_q <= wdata;
      end
   end

   assign rd_val = (out_q & dir_q) | (pin_in & ~dir_q);

endmodule

// File: rtl/pif_irq_ctrl.sv
module pif_irq_ctrl #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ev,
   input  logic [N-1:0] clr,
   input  logic         en_wr,
   input  logic [N:0]   en_wdata,
   output logic [N-1:0] flags_q,
   output logic [N-1:0] en_q,
   output logic         irq_q
);

   logic [N-1:0] flags_d;
   logic [N-1:0] en_d;

   always_comb begin
      flags_d = (flags_q & ~clr) | ev;
      en_d    = en_q;
      if (en_wr) begin
         if (en_wdata[N]) en_d = en_q | en_wdata[N-1:0];
         else             en_d = en_q & ~en_wdata[N-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         en_q    <= '0;
         irq_q   <= 1'b0;
      end else begin
         flags_q <= flags_d;
         en_q    <= en_d;
         irq_q   <= |(flags_d & en_d);
      end
   end

endmodule

// File: rtl/pif_unit.sv
module pif_unit
   import pif_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int FLAG_N = DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc,
   input  logic              wr,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [FLAG_N-1:0] ev,
   output logic              irq,
   input  logic [DATA_W-1:0] pa_in,
   output logic [DATA_W-1:0] pa_out,
   output logic [DATA_W-1:0] pa_oe,
   input  logic [DATA_W-1:0] pb_in,
   output logic [DATA_W-1:0] pb_out,
   output logic [DATA_W-1:0] pb_oe
);

   reg_idx_e ridx;
   logic     rd_acc;
   logic     wr_acc;

   assign ridx   = reg_idx_e'(idx);
   assign rd_acc = acc && !wr;
   assign wr_acc = acc && wr;

   // ports: element 0 is A, element 1 is B
   logic [N_PORTS-1:0] p_wr_out;
   logic [N_PORTS-1:0] p_wr_dir;
   logic [DATA_W-1:0]  p_pin  [N_PORTS];
   logic [DATA_W-1:0]  p_out  [N_PORTS];
   logic [DATA_W-1:0]  p_dir  [N_PORTS];
   logic [DATA_W-1:0]  p_rd   [N_PORTS];

   assign p_wr_out[0] = wr_acc && (ridx == RI_OUT_A || ridx == RI_OUT_A_NH);
   assign p_wr_dir[0] = wr_acc && (ridx == RI_DIR_A);
   assign p_wr_out[1] = wr_acc && (ridx == RI_OUT_B);
   assign p_wr_dir[1] = wr_acc && (ridx == RI_DIR_B);
   assign p_pin[0]    = pa_in;
   assign p_pin[1]    = pb_in;

   for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      pif_port #(.W(DATA_W)) u_port (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_out (p_wr_out[p]),
         .wr_dir (p_wr_dir[p]),
         .wdata  (wdata),
         .pin_in (p_pin[p]),
         .out_q  (p_out[p]),
         .dir_q  (p_dir[p]),
         .rd_val (p_rd[p])
      );
   end

   assign pa_out = p_out[0];
   assign pa_oe  = p_dir[0];
   assign pb_out = p_out[1];
   assign pb_oe  = p_dir[1];

   // plain storage bytes at consecutive indices starting at RI_SHIFT
   logic [DATA_W-1:0] ctl_q [N_CTL_REGS];

   for (genvar k = 0; k < N_CTL_REGS; k++) begin : g_ctl
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(int'(RI_SHIFT) + k);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      ctl_q[k] <= '0;
         else if (wr_acc && idx == MY_IDX) ctl_q[k] <= wdata;
      end
   end

   // flag clears: explicit flag write plus timer byte side effects
   logic [FLAG_N-1:0] clr;
   logic              t2_clr;
   logic              t1_clr;
   logic [FLAG_N-1:0] flags_q;
   logic [FLAG_N-1:0] en_q;

   assign t2_clr = (rd_acc && ridx == RI_T2_CNT_LO) || (wr_acc && ridx == RI_T2_CNT_HI);
   assign t1_clr = (rd_acc && ridx == RI_T1_CNT_LO) || (wr_acc && ridx == RI_T1_CNT_HI);

   always_comb begin
      clr = '0;
      if (wr_acc && ridx == RI_FLAGS) clr = wdata[FLAG_N-1:0];
      clr[FB_TMR2] = clr[FB_TMR2] | t2_clr;
      clr[FB_TMR1] = clr[FB_TMR1] | t1_clr;
   end

   pif_irq_ctrl #(.N(FLAG_N)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev),
      .clr      (clr),
      .en_wr    (wr_acc && ridx == RI_ENABLES),
      .en_wdata (wdata),
      .flags_q  (flags_q),
      .en_q     (en_q),
      .irq_q    (irq)
   );

   always_comb begin
      unique case (ridx)
         RI_OUT_B:                rdata = p_rd[1];
         RI_OUT_A, RI_OUT_A_NH:   rdata = p_rd[0];
         RI_DIR_B:                rdata = p_dir[1];
         RI_DIR_A:                rdata = p_dir[0];
         RI_SHIFT:                rdata = ctl_q[0];
         RI_AUX_CTL:              rdata = ctl_q[1];
         RI_PER_CTL:              rdata = ctl_q[2];
         RI_FLAGS:                rdata = {|(flags_q & en_q), flags_q};
         RI_ENABLES:              rdata = {1'b1, en_q};
         default:                 rdata = '0;
      endcase
   end

endmodule

// File: rtl/pif_regfile.sv
module pif_regfile
   import pif_pkg::*;
#(
   parameter int UNITS    = 2,
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 14,
   parameter int IDX_LSB  = 9,
   parameter int UNIT_BIT = 13,
   localparam int FLAG_N  = DATA_W - 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_sel,
   input  logic                     bus_wr,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   input  logic [UNITS*FLAG_N-1:0]  ev_strobe,
   output logic [UNITS-1:0]         irq,
   input  logic [UNITS*DATA_W-1:0]  pa_in,
   output logic [UNITS*DATA_W-1:0]  pa_out,
   output logic [UNITS*DATA_W-1:0]  pa_oe,
   input  logic [UNITS*DATA_W-1:0]  pb_in,
   output logic [UNITS*DATA_W-1:0]  pb_out,
   output logic [UNITS*DATA_W-1:0]  pb_oe
);

   if (UNITS < 1 || UNITS > 2) begin : g_bad_units
      $error("pif_regfile: UNITS must be 1 or 2");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("pif_regfile: DATA_W must be at least 8");
   end
   if (IDX_LSB + IDX_W > ADDR_W) begin : g_bad_idx
      $error("pif_regfile: index field exceeds address width");
   end
   if (UNITS == 2 && (UNIT_BIT >= ADDR_W ||
       (UNIT_BIT >= IDX_LSB && UNIT_BIT < IDX_LSB + IDX_W))) begin : g_bad_ubit
      $error("pif_regfile: unit select bit misplaced");
   end

   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] u_rd [UNITS];
   logic [UNITS-1:0]  u_hit;
   logic              unused_addr;

   assign idx         = bus_addr[IDX_LSB +: IDX_W];
   assign unused_addr = ^bus_addr;

   if (UNITS == 2) begin : g_two
      assign u_hit[0]  = bus_sel && !bus_addr[UNIT_BIT];
      assign u_hit[1]  = bus_sel &&  bus_addr[UNIT_BIT];
      assign bus_rdata = bus_addr[UNIT_BIT] ? u_rd[1] : u_rd[0];
   end else begin : g_one
      assign u_hit[0]  = bus_sel;
      assign bus_rdata = u_rd[0];
   end

   for (genvar u = 0; u < UNITS; u++) begin : g_unit
      pif_unit #(.DATA_W(DATA_W)) u_unit (
         .clk    (clk),
         .rst_n  (rst_n),
         .acc    (u_hit[u]),
         .wr     (bus_wr),
         .idx    (idx),
         .wdata  (bus_wdata),
         .rdata  (u_rd[u]),
         .ev     (ev_strobe[u*FLAG_N +: FLAG_N]),
         .irq    (irq[u]),
         .pa_in  (pa_in[u*DATA_W +: DATA_W]),
         .pa_out (pa_out[u*DATA_W +: DATA_W]),
         .pa_oe  (pa_oe[u*DATA_W +: DATA_W]),
         .pb_in  (pb_in[u*DATA_W +: DATA_W]),
         .pb_out (pb_out[u*DATA_W +: DATA_W]),
         .pb_oe  (pb_oe[u*DATA_W +: DATA_W])
      );
   end

endmodule

// File: rtl/pif_regfile_chk.sv
module pif_regfile_chk #(
   parameter int UNITS    = 2,
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 14,
   parameter int IDX_LSB  = 9,
   parameter int UNIT_BIT = 13
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          bus_sel,
   input logic                          bus_wr,
   input logic [ADDR_W-1:0]             bus_addr,
   input logic [DATA_W-1:0]             bus_wdata,
   input logic [DATA_W-1:0]             bus_rdata,
   input logic [UNITS*(DATA_W-1)-1:0]   ev_strobe,
   input logic [UNITS-1:0]              irq,
   input logic [UNITS*DATA_W-1:0]       pa_oe
);

   logic [3:0] idx;
   int         cu;
   logic       rd;
   logic       clr_all_u0;

   assign idx = bus_addr[IDX_LSB +: 4];
   assign cu  = (UNITS > 1) ? int'(bus_addr[UNIT_BIT]) : 0;
   assign rd  = bus_sel && !bus_wr;
   assign clr_all_u0 = bus_sel && bus_wr && idx == 4'd13 && cu == 0 &&
                       bus_wdata[DATA_W-2:0] == '1 && ev_strobe[DATA_W-2:0] == '0;

   assert_enable_top_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && idx == 4'd14) |-> bus_rdata[DATA_W-1]);

   assert_irq_matches_summary_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && idx == 4'd13) |-> (bus_rdata[DATA_W-1] == irq[cu]));

   assert_timer_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && idx >= 4'd4 && idx <= 4'd9) |-> (bus_rdata == '0));

   assert_oe_follows_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && idx == 4'd3) |-> (bus_rdata == pa_oe[cu*DATA_W +: DATA_W]));

   assert_clear_all_drops_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all_u0 |=> !irq[0]);

endmodule

bind pif_regfile pif_regfile_chk #(
   .UNITS(UNITS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
   .IDX_LSB(IDX_LSB), .UNIT_BIT(UNIT_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .ev_strobe(ev_strobe), .irq(irq), .pa_oe(pa_oe)
);

// File: tb/pif_regfile_bench.sv
module pif_regfile_bench;

   localparam int U = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [13:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [13:0] ev_strobe = '0;
   logic [1:0]  irq;
   logic [15:0] pa_in = '0, pb_in = '0;
   logic [15:0] pa_out, pa_oe, pb_out, pb_oe;

   int checks = 0;
   int errors = 0;
   logic [6:0] en_m [U];
   logic [6:0] fl_m [U];

   always #10 clk = ~clk;

   pif_regfile u_pif_regfile (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_strobe(ev_strobe), .irq(irq),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [13:0] adr(input int u, input int idx, input int junk);
      return 14'((u << 13) | (idx << 9) | (junk & 9'h1FF));
   endfunction

   task automatic wr(input int u, input int idx, input int d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = adr(u, idx, d * 3); bus_wdata = 8'(d);
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input int u, input int idx, output int d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 0; bus_addr = adr(u, idx, idx * 17);
      #2 d = int'(bus_rdata);
      @(negedge clk);
      bus_sel = 0;
   endtask

   task automatic pulse(input int u, input int m);
      @(negedge clk);
      ev_strobe = '0;
      ev_strobe[u*7 +: 7] = 7'(m);
      @(negedge clk);
      ev_strobe = '0;
      fl_m[u] = fl_m[u] | 7'(m);
   endtask

   function automatic int ifr_exp(input int u);
      return {24'd0, |(fl_m[u] & en_m[u]), fl_m[u]};
   endfunction

   task automatic chk_ifr(input string req, input int u);
      int d;
      rd(u, 13, d);
      chk(req, d, ifr_exp(u));
      chk(req, int'(irq[u]), int'(|(fl_m[u] & en_m[u])));
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int d;
      for (int u = 0; u < U; u++) begin en_m[u] = '0; fl_m[u] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R2: reset state
      pa_in = 16'hA53C; pb_in = 16'h0FF1;
      #2;
      chk("R2 irq", int'(irq), 0);
      chk("R2 oe", int'({pa_oe, pb_oe}), 0);
      for (int i = 0; i < 16; i++) begin
         int e;
         rd(0, i, d);
         e = (i == 1 || i == 15) ? 'h3C : (i == 0) ? 'hF1 : (i == 14) ? 'h80 : 0;
         chk($sformatf("R2 idx %0d", i), d, e);
      end

      // R3: enable set/clear sweep
      for (int u = 0; u < U; u++) begin
         for (int i = 0; i < 16; i++) begin
            int v = (i * 37 + 5) & 255;
            v = (i % 2 == 0) ? (v | 'h80) : (v & 'h7F);
            wr(u, 14, v);
            if (v & 'h80) en_m[u] = en_m[u] | 7'(v);
            else          en_m[u] = en_m[u] & ~7'(v);
            rd(u, 14, d);
            chk("R3 enable readback", d, {24'd0, 1'b1, en_m[u]});
         end
         wr(u, 14, 'h7F); en_m[u] = '0;
      end

      // R5 R6: each event bit, alone-enabled and all-but-enabled
      for (int u = 0; u < U; u++) begin
         for (int b = 0; b < 7; b++) begin
            for (int m = 0; m < 2; m++) begin
               int e = (m == 0) ? (1 << b) : ('h7F & ~(1 << b));
               wr(u, 14, 'h7F); wr(u, 14, 'h80 | e); en_m[u] = 7'(e);
               pulse(u, 1 << b);
               chk_ifr($sformatf("R5 R6 unit %0d bit %0d", u, b), u);
               chk("R1 other unit irq", int'(irq[1-u]), 0);
               wr(u, 13, 'h7F); fl_m[u] = '0;
               chk_ifr("R4 clear all", u);
            end
         end
      end

      // R4: partial clears and collision with a strobe
      wr(0, 14, 'hFF); en_m[0] = 7'h7F;
      pulse(0, 'h55); pulse(0, 'h2A);
      chk_ifr("R5 multi strobe", 0);
      wr(0, 13, 'h93); fl_m[0] = fl_m[0] & ~7'h13;
      chk_ifr("R4 partial clear", 0);
      wr(0, 13, 'h0C); fl_m[0] = fl_m[0] & ~7'h0C;
      chk_ifr("R4 partial clear 2", 0);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = adr(0, 13, 0); bus_wdata = 8'h7F;
      ev_strobe[6:0] = 7'h09;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0; ev_strobe = '0;
      fl_m[0] = 7'h09;
      chk_ifr("R4 strobe beats clear", 0);
      wr(0, 13, 'h7F); fl_m[0] = '0;

      // R7: timer side effects
      pulse(0, 'h60);
      rd(0, 9, d); wr(0, 8, 'h11); rd(0, 5, d); wr(0, 4, 'h22);
      rd(0, 6, d); wr(0, 6, 1); rd(0, 7, d); wr(0, 7, 2);
      chk_ifr("R7 neutral accesses", 0);
      rd(0, 8, d); fl_m[0] = fl_m[0] & ~7'h20;
      chk_ifr("R7 read idx8", 0);
      wr(0, 5, 'hFF); fl_m[0] = fl_m[0] & ~7'h40;
      chk_ifr("R7 write idx5", 0);
      pulse(0, 'h60);
      wr(0, 9, 0); fl_m[0] = fl_m[0] & ~7'h20;
      chk_ifr("R7 write idx9", 0);
      rd(0, 4, d); fl_m[0] = fl_m[0] & ~7'h40;
      chk_ifr("R7 read idx4", 0);

      // R8 R9: port sweep over both units and ports
      for (int i = 0; i < 12; i++) begin
         for (int u = 0; u < U; u++) begin
            int dr = (i * 53 + 7 + u * 11) & 255;
            int o  = (i * 91 + 3 + u * 5) & 255;
            int p  = (i * 29 + 200) & 255;
            int db = (dr ^ 'h5A) & 255;
            int ob = (o + 77) & 255;
            wr(u, 3, dr);
            wr(u, (i % 2 == 0) ? 1 : 15, o);
            wr(u, 2, db); wr(u, 0, ob);
            pa_in[u*8 +: 8] = 8'(p); pb_in[u*8 +: 8] = 8'(p ^ 'hFF);
            rd(u, 1, d);  chk("R8 port A read", d, (o & dr) | (p & ~dr & 255));
            rd(u, 15, d); chk("R9 alias read", d, (o & dr) | (p & ~dr & 255));
            rd(u, 0, d);  chk("R8 port B read", d, (ob & db) | ((p ^ 'hFF) & ~db & 255));
            chk("R8 A oe/out", int'({pa_oe[u*8 +: 8], pa_out[u*8 +: 8]}), (dr << 8) | o);
            chk("R8 B oe/out", int'({pb_oe[u*8 +: 8], pb_out[u*8 +: 8]}), (db << 8) | ob);
         end
      end

      // R10 R1: storage bytes, timer zeros, unit isolation
      for (int k = 10; k < 13; k++) begin
         wr(0, k, k * 19); wr(1, k, 255 - k);
         rd(0, k, d); chk("R10 R1 storage u0", d, (k * 19) & 255);
         rd(1, k, d); chk("R10 R1 storage u1", d, 255 - k);
      end
      for (int k = 4; k < 10; k++) begin
         wr(1, k, 'hA5);
         rd(1, k, d); chk("R10 timer zero", d, 0);
      end
      wr(1, 14, 'h8F); en_m[1] = 7'h0F;
      rd(0, 14, d); chk("R1 enables isolated", d, {24'd0, 1'b1, en_m[0]});

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule